// File: doc/BRIEF.md
# Power Supply Sequencing Supervisor

This block is the timing and control core of a switching power supply supervisor. Digital flags from external comparators arrive as inputs: overvoltage on the 3.3 V, 5 V and 12 V rails, undervoltage on the 3.3 V and 5 V rails, and a power-good-input level. An active-low supply-on request also arrives as an input. The block drives a shutdown output (high keeps the supply off) and a power-good output.

Every input first passes through a two-flop synchronizer and then a filter. The comparator flags use a short deglitch window. The on request uses a long debounce window. Turn-on has no added delay. Turn-off waits a fixed delay after the debounced release, and a new request during that delay cancels the shutdown. For a fixed window after turn-on, undervoltage cannot trip a fault. Any overvoltage, or any undervoltage once that window has expired, latches the shutdown output high. Only a debounced release of the request clears that latch. Power-good rises only after its conditions have held for a long delay.

All times are counted in pulses of a clock-enable tick, and parameters set each count. Register reset is asynchronous and active-low, and its release is synchronized inside the block.

Top module: `pwr_seq_ctrl`

## Requirements
- R1: During reset and after its release, with the request inactive, `fault_o` is 1 and `pgood_o` is 0.
- R2: A level change on `ov_i`, `uv_i` or `pgi_i` is seen only after the synchronized value has differed from the accepted value on DGL_TICKS consecutive ticks. A pulse that spans fewer ticks has no effect on either output.
- R3: A change on `on_req_n_i` is accepted only after it has held for DBNC_TICKS consecutive ticks.
- R4: In the off state, with the fault latch clear, `fault_o` falls in the cycle after the request becomes accepted as active. No further delay is added.
- R5: After the request is accepted as released, `fault_o` stays 0 until OFF_DLY_TICKS further ticks have passed, and then rises.
- R6: If the request is accepted as active again while the turn-off delay runs, the supply returns to the on state and `fault_o` stays 0.
- R7: While the supply is on or turning off, a filtered overvoltage on any bit of `ov_i` (bit 0 = 3.3 V, bit 1 = 5 V, bit 2 = 12 V) latches `fault_o` high and drops `pgood_o`.
- R8: Undervoltage on `uv_i` (bit 0 = 3.3 V, bit 1 = 5 V) trips no fault until UV_MASK_TICKS ticks have passed since turn-on. After that it latches `fault_o` high.
- R9: Once latched, `fault_o` stays high after the fault flags clear and while the request stays active. It clears only when the accepted request goes from active to released. A later request then turns the supply on.
- R10: `pgood_o` rises after PG_DLY_TICKS ticks during which all of these held: supply on, filtered power-good input high, and no filtered undervoltage or overvoltage.
- R11: `pgood_o` falls in the same cycle that any of those conditions fails, including the start of turn-off. When the conditions return, the delay count starts again from zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick_i | input | 1 | Clock-enable pulse; the unit for every delay |
| on_req_n_i | input | 1 | Supply-on request, active low, asynchronous |
| ov_i | input | 3 | Overvoltage flags: bit 0 3.3 V, bit 1 5 V, bit 2 12 V |
| uv_i | input | 2 | Undervoltage flags: bit 0 3.3 V, bit 1 5 V |
| pgi_i | input | 1 | Power-good input level |
| fault_o | output | 1 | Shutdown output; 1 keeps the supply off |
| pgood_o | output | 1 | Power-good output |

## Verification
The hardest state to reach from the ports is the abort of a turn-off. The debounced release has to be accepted first. Then a fresh request has to finish its own debounce before the shorter turn-off delay runs out. The bench uses a turn-off delay longer than one debounce window and reasserts the request a few cycles after the release is accepted. A second hard case is an undervoltage that starts inside the start-up mask and is still present when the mask expires. The bench holds the flag from shortly after turn-on until the latch trips. A behavioural model runs alongside the design and is compared with both outputs on every clock.

// File: rtl/psq_pkg.sv
package psq_pkg;
  localparam int unsigned OV_RAILS = 3;
  localparam int unsigned UV_RAILS = 2;

  typedef enum logic [1:0] {
    ST_OFF  = 2'd0,
    ST_ON   = 2'd1,
    ST_STOP = 2'd2
  } psq_state_e;
endpackage

// File: rtl/psq_rst_sync.sv
module psq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_ns_o
);
  logic stg1_q, stg2_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg1_q <= 1'b0;
      stg2_q <= 1'b0;
    end else begin
      stg1_q <= 1'b1;
      stg2_q <= stg1_q;
    end
  end

  assign rst_ns_o = stg2_q;
endmodule

// File: rtl/psq_filter.sv
module psq_filter #(
  parameter int unsigned HOLD_TICKS = 8,
  parameter bit          RST_VAL    = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic raw_i,
  output logic level_o
);
  localparam int unsigned CW = $clog2(HOLD_TICKS + 1);

  logic          sync1_q, sync2_q;
  logic          level_q, level_d;
  logic [CW-1:0] cnt_q, cnt_d;

  always_comb begin
    level_d = level_q;
    cnt_d   = cnt_q;
    if (sync2_q == level_q) begin
      cnt_d = '0;
    end else if (tick_i) begin
      if (cnt_q == CW'(HOLD_TICKS - 1)) begin
        level_d = sync2_q;
        cnt_d   = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync1_q <= RST_VAL;
      sync2_q <= RST_VAL;
      level_q <= RST_VAL;
      cnt_q   <= '0;
    end else begin
      sync1_q <= raw_i;
      sync2_q <= sync1_q;
      level_q <= level_d;
      cnt_q   <= cnt_d;
    end
  end

  assign level_o = level_q;

  // R2: the accepted level moves only on a tick
  p_level_on_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> $stable(level_q));
endmodule

// File: rtl/psq_pg_timer.sv
module psq_pg_timer #(
  parameter int unsigned PG_DLY_TICKS = 30000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic cond_i,
  output logic pgood_o
);
  localparam int unsigned CW = $clog2(PG_DLY_TICKS + 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          done_q, done_d;

  always_comb begin
    cnt_d  = cnt_q;
    done_d = done_q;
    if (!cond_i) begin
      cnt_d  = '0;
      done_d = 1'b0;
    end else if (tick_i && !done_q) begin
      if (cnt_q == CW'(PG_DLY_TICKS - 1)) begin
        done_d = 1'b1;
        cnt_d  = '0;
      end else begin
        cnt_d = cnt_q + CW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      done_q <= done_d;
    end
  end

  assign pgood_o = done_q & cond_i;

  // R10: power-good can only rise on the edge after a tick
  p_pg_rise_tick_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pgood_o) |-> $past(tick_i));
  // R11: a failed condition restarts the delay from zero
  p_pg_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !cond_i |=> (cnt_q == '0 && !done_q));
endmodule

// File: rtl/psq_seq.sv
module psq_seq
  import psq_pkg::*;
#(
  parameter int unsigned UV_MASK_TICKS = 7500,
  parameter int unsigned OFF_DLY_TICKS = 230
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick_i,
  input  logic req_n_i,
  input  logic ov_any_i,
  input  logic uv_any_i,
  output logic on_o,
  output logic fault_o
);
  localparam int unsigned UCW = $clog2(UV_MASK_TICKS + 1);
  localparam int unsigned OCW = $clog2(OFF_DLY_TICKS + 1);

  psq_state_e     state_q, state_d;
  logic           lat_q, lat_d;
  logic           prv_q;
  logic [UCW-1:0] uv_cnt_q, uv_cnt_d;
  logic [OCW-1:0] off_cnt_q, off_cnt_d;
  logic           uv_en, req, released, fault_det, off_done;

  assign uv_en     = (uv_cnt_q == UCW'(UV_MASK_TICKS));
  assign req       = ~req_n_i;
  assign released  = req_n_i & ~prv_q;
  assign fault_det = (state_q != ST_OFF) & (ov_any_i | (uv_en & uv_any_i));
  assign off_done  = tick_i & (off_cnt_q == OCW'(OFF_DLY_TICKS - 1));

  always_comb begin
    state_d = state_q;
    if (fault_det) begin
      state_d = ST_OFF;
    end else begin
      unique case (state_q)
        ST_OFF:  if (req && !lat_q) state_d = ST_ON;
        ST_ON:   if (!req) state_d = ST_STOP;
        ST_STOP: begin
          if (req)           state_d = ST_ON;
          else if (off_done) state_d = ST_OFF;
        end
        default: state_d = ST_OFF;
      endcase
    end
  end

  always_comb begin
    if (fault_det)     lat_d = 1'b1;
    else if (released) lat_d = 1'b0;
    else               lat_d = lat_q;
  end

  always_comb begin
    if (state_q == ST_OFF)      uv_cnt_d = '0;
    else if (tick_i && !uv_en)  uv_cnt_d = uv_cnt_q + UCW'(1);
    else                        uv_cnt_d = uv_cnt_q;
  end

  always_comb begin
    if (state_q != ST_STOP) off_cnt_d = '0;
    else if (tick_i)        off_cnt_d = off_cnt_q + OCW'(1);
    else                    off_cnt_d = off_cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q   <= ST_OFF;
      lat_q     <= 1'b0;
      prv_q     <= 1'b1;
      uv_cnt_q  <= '0;
      off_cnt_q <= '0;
    end else begin
      state_q   <= state_d;
      lat_q     <= lat_d;
      prv_q     <= req_n_i;
      uv_cnt_q  <= uv_cnt_d;
      off_cnt_q <= off_cnt_d;
    end
  end

  assign on_o    = (state_q == ST_ON);
  assign fault_o = (state_q == ST_OFF) | lat_q;

  // R4: an accepted request with a clear latch turns the supply on at once
  p_turn_on_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_OFF && !req_n_i && !lat_q) |=> !fault_o);
  // R6: a renewed request during turn-off goes back to the on state
  p_stop_abort_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_STOP && !req_n_i && !ov_any_i && !(uv_en && uv_any_i))
      |=> (state_q == ST_ON));
  // R7: overvoltage while running latches the fault and turns off
  p_ov_latch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_OFF && ov_any_i) |=> (lat_q && state_q == ST_OFF));
  // R8: undervoltage inside the start-up mask sets no latch
  p_uv_masked_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q != ST_OFF && !uv_en && !ov_any_i) |=> !lat_q);
  // R9: the latch only clears after an accepted release
  p_lat_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(lat_q) |-> $past(req_n_i && !prv_q));
endmodule

// File: rtl/pwr_seq_ctrl.sv
module pwr_seq_ctrl
  import psq_pkg::*;
#(
  parameter int unsigned DGL_TICKS     = 8,
  parameter int unsigned DBNC_TICKS    = 3800,
  parameter int unsigned UV_MASK_TICKS = 7500,
  parameter int unsigned OFF_DLY_TICKS = 230,
  parameter int unsigned PG_DLY_TICKS  = 30000
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick_i,
  input  logic                on_req_n_i,
  input  logic [OV_RAILS-1:0] ov_i,
  input  logic [UV_RAILS-1:0] uv_i,
  input  logic                pgi_i,
  output logic                fault_o,
  output logic                pgood_o
);
  logic                rst_ns;
  logic [OV_RAILS-1:0] ov_f;
  logic [UV_RAILS-1:0] uv_f;
  logic                pgi_f, req_n_f, on_st, pg_cond;

  psq_rst_sync u_rst (
    .clk      (clk),
    .rst_n    (rst_n),
    .rst_ns_o (rst_ns)
  );

  for (genvar i = 0; i < OV_RAILS; i++) begin : g_ov
    psq_filter #(.HOLD_TICKS(DGL_TICKS), .RST_VAL(1'b0)) u_flt (
      .clk(clk), .rst_n(rst_ns), .tick_i(tick_i),
      .raw_i(ov_i[i]), .level_o(ov_f[i])
    );
  end

  for (genvar j = 0; j < UV_RAILS; j++) begin : g_uv
    psq_filter #(.HOLD_TICKS(DGL_TICKS), .RST_VAL(1'b0)) u_flt (
      .clk(clk), .rst_n(rst_ns), .tick_i(tick_i),
      .raw_i(uv_i[j]), .level_o(uv_f[j])
    );
  end

  psq_filter #(.HOLD_TICKS(DGL_TICKS), .RST_VAL(1'b0)) u_pgi_flt (
    .clk(clk), .rst_n(rst_ns), .tick_i(tick_i),
    .raw_i(pgi_i), .level_o(pgi_f)
  );

  psq_filter #(.HOLD_TICKS(DBNC_TICKS), .RST_VAL(1'b1)) u_req_flt (
    .clk(clk), .rst_n(rst_ns), .tick_i(tick_i),
    .raw_i(on_req_n_i), .level_o(req_n_f)
  );

  psq_seq #(
    .UV_MASK_TICKS (UV_MASK_TICKS),
    .OFF_DLY_TICKS (OFF_DLY_TICKS)
  ) u_seq (
    .clk      (clk),
    .rst_n    (rst_ns),
    .tick_i   (tick_i),
    .req_n_i  (req_n_f),
    .ov_any_i (|ov_f),
    .uv_any_i (|uv_f),
    .on_o     (on_st),
    .fault_o  (fault_o)
  );

  assign pg_cond = on_st & pgi_f & ~(|uv_f) & ~(|ov_f);

  psq_pg_timer #(.PG_DLY_TICKS(PG_DLY_TICKS)) u_pg (
    .clk     (clk),
    .rst_n   (rst_ns),
    .tick_i  (tick_i),
    .cond_i  (pg_cond),
    .pgood_o (pgood_o)
  );

  // R11: power-good never stands while the supply is held off
  p_pg_needs_run_r11: assert property (@(posedge clk) disable iff (!rst_ns)
    fault_o |-> !pgood_o);
endmodule

// File: tb/tb_pwr_seq_ctrl.sv
module tb_pwr_seq_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DGL  = 3;
  localparam int DBNC = 6;
  localparam int UVM  = 24;
  localparam int OFFD = 12;
  localparam int PGD  = 12;
  localparam int WD_CYCLES = 20000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b1;
  logic       tick_i = 1'b0;
  logic       on_req_n_i = 1'b1;
  logic [2:0] ov_i = 3'b000;
  logic [1:0] uv_i = 2'b00;
  logic       pgi_i = 1'b0;
  logic       fault_o, pgood_o;

  int    n_tests = 0;
  int    n_fail  = 0;
  bit    cmp_en  = 1'b0;
  bit    finished = 1'b0;
  string tag = "R1";

  pwr_seq_ctrl #(
    .DGL_TICKS(DGL), .DBNC_TICKS(DBNC), .UV_MASK_TICKS(UVM),
    .OFF_DLY_TICKS(OFFD), .PG_DLY_TICKS(PGD)
  ) dut (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .on_req_n_i(on_req_n_i),
    .ov_i(ov_i), .uv_i(uv_i), .pgi_i(pgi_i),
    .fault_o(fault_o), .pgood_o(pgood_o)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- behavioural reference model ----------------
  bit m_r1, m_r2;
  bit ms1[7], ms2[7], mlev[7];
  int mcnt[7];
  int m_st;          // 0 off, 1 on, 2 stopping
  bit m_lat, m_prv, m_done;
  int m_uvc, m_offc, m_pgc;

  function automatic bit m_cond();
    return (m_st == 1) && mlev[5] && !(mlev[3] || mlev[4]) &&
           !(mlev[0] || mlev[1] || mlev[2]);
  endfunction

  function automatic bit m_fault();
    return (m_st == 0) || m_lat;
  endfunction

  function automatic bit m_pg();
    return m_done && m_cond();
  endfunction

  task automatic m_clear();
    for (int i = 0; i < 7; i++) begin
      ms1[i] = (i == 6); ms2[i] = (i == 6); mlev[i] = (i == 6); mcnt[i] = 0;
    end
    m_st = 0; m_lat = 0; m_prv = 1; m_done = 0;
    m_uvc = 0; m_offc = 0; m_pgc = 0;
  endtask

  task automatic m_step();
    bit raw[7];
    bit req, ova, uva, uven, fdet, rel, cnd, tk;
    int nst, lim;
    raw[0] = ov_i[0]; raw[1] = ov_i[1]; raw[2] = ov_i[2];
    raw[3] = uv_i[0]; raw[4] = uv_i[1]; raw[5] = pgi_i; raw[6] = on_req_n_i;
    tk   = tick_i;
    req  = !mlev[6];
    ova  = mlev[0] || mlev[1] || mlev[2];
    uva  = mlev[3] || mlev[4];
    uven = (m_uvc == UVM);
    fdet = (m_st != 0) && (ova || (uven && uva));
    rel  = mlev[6] && !m_prv;
    cnd  = m_cond();
    nst  = m_st;
    if (fdet) nst = 0;
    else if (m_st == 0 && req && !m_lat) nst = 1;
    else if (m_st == 1 && !req) nst = 2;
    else if (m_st == 2 && req) nst = 1;
    else if (m_st == 2 && tk && m_offc == OFFD - 1) nst = 0;
    if (m_st == 0) m_uvc = 0; else if (tk && !uven) m_uvc++;
    if (m_st != 2) m_offc = 0; else if (tk) m_offc++;
    if (fdet) m_lat = 1; else if (rel) m_lat = 0;
    m_prv = mlev[6];
    m_st  = nst;
    if (!cnd) begin m_pgc = 0; m_done = 0; end
    else if (tk && !m_done) begin
      if (m_pgc == PGD - 1) begin m_done = 1; m_pgc = 0; end
      else m_pgc++;
    end
    for (int i = 0; i < 7; i++) begin
      lim = (i == 6) ? DBNC : DGL;
      if (ms2[i] == mlev[i]) mcnt[i] = 0;
      else if (tk) begin
        if (mcnt[i] == lim - 1) begin mlev[i] = ms2[i]; mcnt[i] = 0; end
        else mcnt[i]++;
      end
      ms2[i] = ms1[i];
      ms1[i] = raw[i];
    end
  endtask

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_r1 = 0; m_r2 = 0; m_clear();
    end else begin
      if (!m_r2) m_clear(); else m_step();
      m_r2 = m_r1; m_r1 = 1;
    end
  end

  // ---------------- checking ----------------
  task automatic chk(input string rq, input string what, input logic act, input logic exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s actual=%b expected=%b t=%0t", rq, what, act, exp, $time);
    end
  endtask

  always @(negedge clk) begin
    if (cmp_en && !finished) begin
      chk(tag, "fault_o vs model", fault_o, m_fault());
      chk(tag, "pgood_o vs model", pgood_o, m_pg());
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  initial begin : tick_gen
    int tc = 0;
    forever begin
      @(negedge clk);
      tick_i = (tc == 2);
      tc = (tc == 2) ? 0 : tc + 1;
    end
  end

  initial begin : watchdog
    repeat (WD_CYCLES) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=running expected=finished");
      finish_run();
    end
  end

  initial begin : stim
    #1 rst_n = 1'b0;
    #2 cmp_en = 1'b1;
    cyc(4);
    tag = "R1";
    chk("R1", "fault_o in reset", fault_o, 1'b1);
    chk("R1", "pgood_o in reset", pgood_o, 1'b0);
    rst_n = 1'b1;
    cyc(6);
    chk("R1", "fault_o after reset", fault_o, 1'b1);
    chk("R1", "pgood_o after reset", pgood_o, 1'b0);

    // request on; debounce then immediate turn-on
    tag = "R3";
    pgi_i = 1'b1;
    on_req_n_i = 1'b0;
    cyc(10);
    chk("R3", "fault_o before debounce done", fault_o, 1'b1);
    tag = "R4";
    cyc(20);
    chk("R4", "fault_o after accepted request", fault_o, 1'b0);
    tag = "R10";
    chk("R10", "pgood_o before delay", pgood_o, 1'b0);
    cyc(60);
    chk("R10", "pgood_o after delay", pgood_o, 1'b1);

    // short glitches ignored
    tag = "R2";
    uv_i[0] = 1'b1; cyc(2); uv_i[0] = 1'b0;
    cyc(15);
    chk("R2", "pgood_o after uv glitch", pgood_o, 1'b1);
    ov_i[2] = 1'b1; cyc(2); ov_i[2] = 1'b0;
    cyc(15);
    chk("R2", "fault_o after ov glitch", fault_o, 1'b0);

    // power-good drop and restart
    tag = "R11";
    pgi_i = 1'b0;
    cyc(15);
    chk("R11", "pgood_o after pgi low", pgood_o, 1'b0);
    pgi_i = 1'b1;
    cyc(20);
    chk("R11", "pgood_o delay restarted", pgood_o, 1'b0);
    cyc(50);
    chk("R10", "pgood_o after second delay", pgood_o, 1'b1);

    // 12 V overvoltage latches
    tag = "R7";
    ov_i[2] = 1'b1;
    cyc(15);
    chk("R7", "fault_o on ov 12 V", fault_o, 1'b1);
    chk("R7", "pgood_o on ov 12 V", pgood_o, 1'b0);
    ov_i[2] = 1'b0;
    tag = "R9";
    cyc(20);
    chk("R9", "fault_o held after ov clears", fault_o, 1'b1);
    on_req_n_i = 1'b1;
    cyc(30);
    chk("R9", "fault_o in off after release", fault_o, 1'b1);
    on_req_n_i = 1'b0;
    cyc(30);
    chk("R9", "fault_o after new request", fault_o, 1'b0);

    // undervoltage during start-up mask, then after it
    tag = "R8";
    uv_i[1] = 1'b1;
    cyc(20);
    chk("R8", "fault_o with uv inside mask", fault_o, 1'b0);
    chk("R8", "pgood_o with uv inside mask", pgood_o, 1'b0);
    cyc(80);
    chk("R8", "fault_o with uv after mask", fault_o, 1'b1);
    uv_i[1] = 1'b0;
    on_req_n_i = 1'b1;
    cyc(30);
    on_req_n_i = 1'b0;
    cyc(30);
    chk("R8", "fault_o after recovery", fault_o, 1'b0);

    // turn-off delay
    tag = "R5";
    cyc(60);
    chk("R10", "pgood_o before turn-off", pgood_o, 1'b1);
    on_req_n_i = 1'b1;
    cyc(25);
    chk("R11", "pgood_o at turn-off start", pgood_o, 1'b0);
    chk("R5", "fault_o during off delay", fault_o, 1'b0);
    cyc(45);
    chk("R5", "fault_o after off delay", fault_o, 1'b1);

    // abort turn-off
    tag = "R6";
    on_req_n_i = 1'b0;
    cyc(30);
    on_req_n_i = 1'b1;
    cyc(25);
    on_req_n_i = 1'b0;
    cyc(40);
    chk("R6", "fault_o after aborted turn-off", fault_o, 1'b0);
    cyc(25);
    chk("R6", "fault_o still on", fault_o, 1'b0);

    // 3.3 V overvoltage
    tag = "R7";
    ov_i[0] = 1'b1;
    cyc(15);
    chk("R7", "fault_o on ov 3.3 V", fault_o, 1'b1);
    ov_i[0] = 1'b0;
    cyc(5);
    finish_run();
  end
endmodule